// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit single-precision operands through a valid/ready handshake and returns their product in the same format. In the word, bit 31 holds the sign, bits 30:23 hold an exponent stored with a bias of 127, and bits 22:0 hold the fraction of a significand 1.F whose leading one is not stored. An operand whose exponent field is zero is read as zero. Exponent field 255 is never presented to the block.

A small state machine steps each operation through a fixed order. ST_IDLE waits for an operand pair. ST_EXP adds the two stored exponents and removes one bias. ST_MUL forms the 48-bit product of the two 24-bit significands. ST_NORM shifts a product of 2.0 or more right by one place and bumps the exponent. At the same time it splits off the guard bit, the round bit and a sticky OR of every lower bit. ST_RND rounds to nearest with ties to even. If rounding carries out, it renormalizes. ST_SIGN applies the XOR sign and packs the word. There it flushes an exponent of zero or less to a signed zero, and it saturates an exponent of 255 or more to the largest finite value. ST_OUT presents the result until the consumer takes it.

The transitions are as follows. ST_IDLE goes to ST_EXP when in_valid is high. ST_EXP, ST_MUL, ST_NORM, ST_RND and ST_SIGN each advance unconditionally to the next state. ST_OUT returns to ST_IDLE when out_ready is high and otherwise stays in ST_OUT.

Top module: `spfp_mul`

## Requirements
- R1: Operands and result use bit 31 as the sign, bits 30:23 as the exponent with a bias of 127, and bits 22:0 as the fraction of 1.F. The product of two normal operands is exact when it fits in 24 significand bits, for example 0x3CC00000 × 0x40000000 = 0x3D400000.
- R2: The result exponent is e_a + e_b − 127. One is added to it when the significand product is 2.0 or more, for example 0x3FC00000 × 0x3FC00000 = 0x40100000.
- R3: The result sign is the XOR of the two operand signs. This holds for zero, flushed and saturated results as well.
- R4: Rounding is to nearest with ties to even, based on the guard bit, the round bit and the sticky bit (the OR of all lower product bits). For example, 0x3F800001 × 0x3FC00000 = 0x3FC00002, 0x3F800003 × 0x3FC00000 = 0x3FC00004, and 0x3F800001 × 0x3F800001 = 0x3F800002.
- R5: A rounding carry out of the 24-bit significand yields significand 1.0 and exponent + 1. For example, 0x3FFFFFFE × 0x3F800001 = 0x40000000.
- R6: If either operand has exponent field 0, the result is a zero carrying the R3 sign. For example, 0x00000000 × 0xC0000000 = 0x80000000.
- R7: A final exponent of 255 or more gives sign | 0x7F7FFFFF. No output ever has exponent field 255.
- R8: A final exponent of 0 or less gives a signed zero. No output has exponent field 0 with a nonzero fraction.
- R9: in_ready is high exactly in ST_IDLE. Operands are taken only on a cycle with in_valid and in_ready both high. in_valid and operand values seen while busy are ignored.
- R10: out_valid first rises in the sixth cycle after the accepting cycle. While out_ready is low, out_valid and out_prod hold steady.
- R11: During and just after reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block is idle and takes a pair |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 32 | Product |

## Verification
The checker's sign, zero and latency properties assume one operation in flight at a time. They also assume no operand ever has exponent field 255, so the no-infinity property cannot be defeated by an input infinity. The stimulus draws random exponents only from 0 to 254. It also drives in_valid with junk data while the block is busy, which the block must ignore. The consumer side throttles out_ready randomly so that the hold property and the return to ST_IDLE are both exercised.

// File: rtl/spfp_pkg.sv
package spfp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXP,
        ST_MUL,
        ST_NORM,
        ST_RND,
        ST_SIGN,
        ST_OUT
    } spfp_state_e;

endpackage

// File: rtl/spfp_sig_mult.sv
module spfp_sig_mult #(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W-1:0]   sig_a,
    input  logic [SIG_W-1:0]   sig_b,
    output logic [2*SIG_W-1:0] sig_prod
);

    localparam int PW = 2 * SIG_W;

    always_comb begin
        sig_prod = PW'(sig_a) * PW'(sig_b);
    end

endmodule

// File: rtl/spfp_norm.sv
module spfp_norm #(
    parameter int SIG_W  = 24,
    parameter int ESUM_W = 10
) (
    input  logic [2*SIG_W-1:0]        prod,
    input  logic signed [ESUM_W-1:0]  exp_in,
    output logic [SIG_W-1:0]          kept,
    output logic                      guard,
    output logic                      rbit,
    output logic                      sticky,
    output logic signed [ESUM_W-1:0]  exp_out
);

    localparam int PW = 2 * SIG_W;

    always_comb begin
        if (prod[PW-1]) begin
            kept    = prod[PW-1 -: SIG_W];
            guard   = prod[PW-1-SIG_W];
            rbit    = prod[PW-2-SIG_W];
            sticky  = |prod[PW-3-SIG_W:0];
            exp_out = exp_in + ESUM_W'(1);
        end else begin
            kept    = prod[PW-2 -: SIG_W];
            guard   = prod[PW-2-SIG_W];
            rbit    = prod[PW-3-SIG_W];
            sticky  = |prod[PW-4-SIG_W:0];
            exp_out = exp_in;
        end
    end

endmodule

// File: rtl/spfp_round.sv
module spfp_round #(
    parameter int SIG_W  = 24,
    parameter int ESUM_W = 10
) (
    input  logic [SIG_W-1:0]          kept,
    input  logic                      guard,
    input  logic                      rbit,
    input  logic                      sticky,
    input  logic signed [ESUM_W-1:0]  exp_in,
    output logic [SIG_W-2:0]          frac,
    output logic signed [ESUM_W-1:0]  exp_out
);

    logic           inc;
    logic [SIG_W:0] sum;

    always_comb begin
        inc = guard & (rbit | sticky | kept[0]);
        sum = {1'b0, kept} + (SIG_W+1)'(inc);
        if (sum[SIG_W]) begin
            frac    = sum[SIG_W-1:1];
            exp_out = exp_in + ESUM_W'(1);
        end else begin
            frac    = sum[SIG_W-2:0];
            exp_out = exp_in;
        end
    end

endmodule

// File: rtl/spfp_mul.sv
module spfp_mul #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [EXP_W+FRAC_W:0]     in_a,
    input  logic [EXP_W+FRAC_W:0]     in_b,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [EXP_W+FRAC_W:0]     out_prod
);

    import spfp_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PW     = 2 * SIG_W;
    localparam int ESUM_W = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;

    spfp_state_e state, state_nx;

    logic [WORD_W-1:0]        op_a, op_b;
    logic signed [ESUM_W-1:0] exp_r;
    logic                     zero_r;
    logic [PW-1:0]            prod_r;
    logic [SIG_W-1:0]         kept_r;
    logic                     guard_r, rbit_r, sticky_r;
    logic signed [ESUM_W-1:0] nexp_r;
    logic [FRAC_W-1:0]        frac_r;
    logic signed [ESUM_W-1:0] rexp_r;
    logic [WORD_W-1:0]        res_r;

    logic [EXP_W-1:0]         ea, eb;
    logic [PW-1:0]            prod_w;
    logic [SIG_W-1:0]         kept_w;
    logic                     guard_w, rbit_w, sticky_w;
    logic signed [ESUM_W-1:0] nexp_w;
    logic [FRAC_W-1:0]        frac_w;
    logic signed [ESUM_W-1:0] rexp_w;
    logic                     sign_w;
    logic [WORD_W-1:0]        pack_w;

    assign ea = op_a[WORD_W-2 -: EXP_W];
    assign eb = op_b[WORD_W-2 -: EXP_W];

    spfp_sig_mult #(.SIG_W(SIG_W)) u_mult (
        .sig_a    ({1'b1, op_a[FRAC_W-1:0]}),
        .sig_b    ({1'b1, op_b[FRAC_W-1:0]}),
        .sig_prod (prod_w)
    );

    spfp_norm #(.SIG_W(SIG_W), .ESUM_W(ESUM_W)) u_norm (
        .prod    (prod_r),
        .exp_in  (exp_r),
        .kept    (kept_w),
        .guard   (guard_w),
        .rbit    (rbit_w),
        .sticky  (sticky_w),
        .exp_out (nexp_w)
    );

    spfp_round #(.SIG_W(SIG_W), .ESUM_W(ESUM_W)) u_round (
        .kept    (kept_r),
        .guard   (guard_r),
        .rbit    (rbit_r),
        .sticky  (sticky_r),
        .exp_in  (nexp_r),
        .frac    (frac_w),
        .exp_out (rexp_w)
    );

    // Sign is decided last, then range limits are applied.
    always_comb begin
        sign_w = op_a[WORD_W-1] ^ op_b[WORD_W-1];
        if (zero_r || rexp_r <= 0) begin
            pack_w = {sign_w, {(WORD_W-1){1'b0}}};
        end else if (rexp_r >= EMAX) begin
            pack_w = {sign_w, EXP_W'(EMAX - 1), {FRAC_W{1'b1}}};
        end else begin
            pack_w = {sign_w, rexp_r[EXP_W-1:0], frac_r};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_EXP;
            ST_EXP:  state_nx = ST_MUL;
            ST_MUL:  state_nx = ST_NORM;
            ST_NORM: state_nx = ST_RND;
            ST_RND:  state_nx = ST_SIGN;
            ST_SIGN: state_nx = ST_OUT;
            ST_OUT:  if (out_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_OUT);
        out_prod  = res_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a     <= '0;
            op_b     <= '0;
            exp_r    <= '0;
            zero_r   <= 1'b0;
            prod_r   <= '0;
            kept_r   <= '0;
            guard_r  <= 1'b0;
            rbit_r   <= 1'b0;
            sticky_r <= 1'b0;
            nexp_r   <= '0;
            frac_r   <= '0;
            rexp_r   <= '0;
            res_r    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        op_a <= in_a;
                        op_b <= in_b;
                    end
                end
                ST_EXP: begin
                    exp_r  <= $signed({2'b00, ea}) + $signed({2'b00, eb})
                              - $signed(ESUM_W'(BIAS));
                    zero_r <= (ea == '0) || (eb == '0);
                end
                ST_MUL: begin
                    prod_r <= prod_w;
                end
                ST_NORM: begin
                    kept_r   <= kept_w;
                    guard_r  <= guard_w;
                    rbit_r   <= rbit_w;
                    sticky_r <= sticky_w;
                    nexp_r   <= nexp_w;
                end
                ST_RND: begin
                    frac_r <= frac_w;
                    rexp_r <= rexp_w;
                end
                ST_SIGN: begin
                    res_r <= pack_w;
                end
                ST_OUT: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/spfp_mul_chk.sv
module spfp_mul_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [EXP_W:0]         a_top,
    input logic [EXP_W:0]         b_top,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [EXP_W+FRAC_W:0]  out_prod
);

    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic       sgn_q;
    logic       zero_q;
    logic [2:0] lat_cnt;
    logic       take;

    assign take = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sgn_q   <= 1'b0;
            zero_q  <= 1'b0;
            lat_cnt <= '0;
        end else begin
            if (take) begin
                sgn_q   <= a_top[EXP_W] ^ b_top[EXP_W];
                zero_q  <= (a_top[EXP_W-1:0] == '0) || (b_top[EXP_W-1:0] == '0);
                lat_cnt <= 3'd1;
            end else if (lat_cnt != 3'd0 && lat_cnt != 3'd7) begin
                lat_cnt <= lat_cnt + 3'd1;
            end
        end
    end

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);                                      // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !in_ready);                                           // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_prod));   // R10
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> lat_cnt == 3'd6);                         // R10
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_prod[WORD_W-1] == sgn_q);                    // R3
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && zero_q |-> out_prod[WORD_W-2:0] == '0);           // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_prod[WORD_W-2 -: EXP_W] != '1);              // R7
    AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_prod[WORD_W-2 -: EXP_W] == '0
            |-> out_prod[FRAC_W-1:0] == '0);                           // R8

endmodule

bind spfp_mul spfp_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .a_top     (in_a[EXP_W+FRAC_W -: EXP_W+1]),
    .b_top     (in_b[EXP_W+FRAC_W -: EXP_W+1]),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_prod  (out_prod)
);

// File: tb/spfp_mul_bench.sv
module spfp_mul_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_prod;

    int n_chk = 0;
    int n_bad = 0;
    bit rst_seen = 1'b0;
    bit bp_on = 1'b1;

    logic [31:0] cur_exp = '0;
    string       cur_tag = "";
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          m_idle = 1'b1;
    int          m_cnt = 0;

    always #4 clk = ~clk;

    spfp_mul u_spfp_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_prod  (out_prod)
    );

    // Behavioural product: remainder compare against half an ulp.
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        int ea, eb, e, sh;
        longint unsigned ma, mb, p, kept, rem, half;
        logic s;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        if (ea == 0 || eb == 0) return {s, 31'b0};
        ma = 64'(a[22:0]) + (64'd1 << 23);
        mb = 64'(b[22:0]) + (64'd1 << 23);
        p  = ma * mb;
        e  = ea + eb - 127;
        if (p >= (64'd1 << 47)) begin sh = 24; e = e + 1; end
        else sh = 23;
        kept = p >> sh;
        rem  = p - (kept << sh);
        half = 64'd1 << (sh - 1);
        if (rem > half || (rem == half && kept[0])) kept = kept + 1;
        if (kept == (64'd1 << 24)) begin kept = kept >> 1; e = e + 1; end
        if (e >= 255) return {s, 8'hFE, 23'h7FFFFF};
        if (e <= 0) return {s, 31'b0};
        return {s, e[7:0], kept[22:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, expv, $time);
        end
    endtask

    // Reference model of the handshake, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idle = 1'b1;
            m_cnt  = 0;
            exp_q.delete();
            tag_q.delete();
        end else if (m_idle) begin
            if (in_valid) begin
                m_idle = 1'b0;
                m_cnt  = 1;
                exp_q.push_back(cur_exp);
                tag_q.push_back(cur_tag);
            end
        end else if (m_cnt < 6) begin
            m_cnt++;
        end else if (out_ready) begin
            m_idle = 1'b1;
            m_cnt  = 0;
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            check(in_ready === 1'b1, "R11 in_ready in reset", 32'(in_ready), 32'd1);
            check(out_valid === 1'b0, "R11 out_valid in reset", 32'(out_valid), 32'd0);
        end else begin
            bit ev;
            ev = !m_idle && m_cnt == 6;
            check(in_ready === m_idle, "R9 in_ready", 32'(in_ready), 32'(m_idle));
            check(out_valid === ev, "R10 out_valid", 32'(out_valid), 32'(ev));
            if (ev && exp_q.size() > 0)
                check(out_prod === exp_q[0], tag_q[0], out_prod, exp_q[0]);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] e, input string tag, input bit junk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_a = a; in_b = b; cur_exp = e; cur_tag = tag; in_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            // R9: offers while busy must be ignored.
            for (int k = 0; k < 3; k++) begin
                in_a = $urandom; in_b = $urandom;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] rnd_op();
        logic [31:0] v;
        int e;
        v = $urandom;
        case ($urandom % 8)
            0:       e = 0;
            1:       e = 200 + int'($urandom % 55);
            2:       e = 1 + int'($urandom % 40);
            default: e = 100 + int'($urandom % 55);
        endcase
        v[30:23] = 8'(e);
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rst_seen = 1'b1;

        send(32'h3CC00000, 32'h40000000, 32'h3D400000, "R1 encoding", 1'b0);
        send(32'hC8C80000, 32'h3F800000, 32'hC8C80000, "R1 R3 negative encoding", 1'b1);
        send(32'h3FC00000, 32'h3FC00000, 32'h40100000, "R2 normalize shift", 1'b0);
        send(32'h3F800001, 32'h3FC00000, 32'h3FC00002, "R4 tie odd rounds up", 1'b0);
        send(32'h3F800003, 32'h3FC00000, 32'h3FC00004, "R4 tie even stays", 1'b1);
        send(32'h3F800001, 32'h3F800001, 32'h3F800002, "R4 below half truncates", 1'b0);
        send(32'h3F800001, 32'h3FC00001, 32'h3FC00003, "R4 sticky above half", 1'b0);
        send(32'h3FFFFFFE, 32'h3F800001, 32'h40000000, "R5 rounding carry", 1'b0);
        send(32'h00000000, 32'hC0000000, 32'h80000000, "R6 signed zero", 1'b0);
        send(32'h3F800000, 32'h00000000, 32'h00000000, "R6 zero operand b", 1'b0);
        send(32'h7F000000, 32'h7F000000, 32'h7F7FFFFF, "R7 saturate", 1'b0);
        send(32'hFF000000, 32'h7F000000, 32'hFF7FFFFF, "R7 saturate negative", 1'b0);
        send(32'h00800000, 32'h00800000, 32'h00000000, "R8 flush", 1'b0);
        send(32'h80800000, 32'h00800000, 32'h80000000, "R8 flush negative", 1'b0);

        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            a = rnd_op();
            b = rnd_op();
            if (i == 150) bp_on = 1'b0;
            send(a, b, ref_mul(a, b), "R1 R2 R3 R4 random", (i % 7) == 0);
        end

        @(negedge clk);
        while (!(m_idle && exp_q.size() == 0)) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule